// File: doc/BRIEF.md
# Defect Change Interrupt Controller

This block raises a host interrupt whenever one of three receive defect indications changes state: loss of signal, severely errored frame or loss of frame. The defect levels come from a framer that has already decided them. Each level is first re-timed into the local clock. A change is a declaration (0 to 1) or a clearance (1 to 0). A change counts only when the enable bit of that defect is set; it then sets a sticky status bit.

The host uses a small register port. It can write the enable register and read three registers: enable, sticky status (cleared by the read itself) and live level. The interrupt output is high while any sticky bit is set. A read of the status register tells the host which defects changed. That read also re-arms the interrupt. The host then reads the level register to learn the present state of each defect.

All three registers use the same bit positions: bit 0 is loss of signal, bit 1 is severely errored frame and bit 2 is loss of frame. Register addresses are 0 for enable, 1 for status and 2 for level. Address 3 reads as zero.

Top module: `defect_irq_ctrl`

## Requirements
- R1: When a defect input rises from 0 to 1 and its enable bit is set, its status bit (bit 0 loss of signal, bit 1 severely errored frame, bit 2 loss of frame) becomes 1 on the third rising clock edge that samples the new input value.
- R2: When a defect input falls from 1 to 0 and its enable bit is set, its status bit becomes 1 with the same three-edge latency as a rise.
- R3: The enable register at address 0 holds bits 2:0 as read/write. Bits 7:3 read as 0 whatever was written.
- R4: A change that occurs while its enable bit is 0 is never latched. Setting the enable bit later does not make that change appear in status.
- R5: A read at address 1 returns the sticky status bits, and those bits are 0 on the next cycle.
- R6: A change that sets a status bit on the same clock edge as a status read stays set after the read. That read returns the status value from before the change.
- R7: The active-high interrupt output is 1 exactly when at least one status bit is 1.
- R8: After reset, the enable register, status register and read data are 0, and the interrupt is low.
- R9: A read at address 2 returns the re-timed level of each defect, which follows the input after two rising edges. Writes to addresses 1 and 2 have no effect.
- R10: Read data is registered. It shows the addressed register on the cycle after the read strobe and holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| los_in | input | 1 | Loss-of-signal defect level, asynchronous |
| sef_in | input | 1 | Severely-errored-frame defect level, asynchronous |
| lof_in | input | 1 | Loss-of-frame defect level, asynchronous |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 8 | Registered read data |
| irq | output | 1 | Interrupt, active high |

## Verification
Two functions can act on the same status bit in one cycle: a read clears it, and a new enabled change sets it. The bench provokes this on purpose. It drives a defect transition and then issues the status read exactly two edges later, so the read and the latch land on the same edge. The read must return the old value, and a second read must show the newly set bit. A behavioural reference model compares the interrupt and read data on every clock. The run also includes a random phase that mixes toggling defects, enable writes and reads, so many of these collisions happen without being planned.

// File: rtl/defect_irq_pkg.sv
// Package: shared constants for the defect change interrupt controller.
// Assumes three defects in a fixed bit order that software relies on.
package defect_irq_pkg;
    localparam int DEF_W   = 3;
    localparam int REG_W   = 8;
    localparam int ADDR_W  = 2;

    // Bit positions used by every register.
    localparam int BIT_LOS = 0;
    localparam int BIT_SEF = 1;
    localparam int BIT_LOF = 2;

    typedef enum logic [ADDR_W-1:0] {
        A_ENABLE = 2'd0,
        A_STATUS = 2'd1,
        A_LEVEL  = 2'd2,
        A_SPARE  = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/defect_sync.sv
// Module: multi-stage synchronizer chain for a vector of level inputs.
// Assumes inputs are slow levels, so each bit is re-timed on its own.
module defect_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] d_sync
);
    logic [W-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First flop samples the asynchronous input.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= '0;
                    else        stage_q[0] <= d_async;
                end
            end else begin : g_next
                // Later flops shift the sample along the chain.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign d_sync = stage_q[STAGES-1];
endmodule

// File: rtl/defect_edge.sv
// Module: change detector; flags each bit whose level differs from last cycle.
// Assumes a synchronized input; reports rises and falls alike.
module defect_edge #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] level,
    output logic [W-1:0] change
);
    logic [W-1:0] prev_q;

    // Keep a one-cycle-old copy of the level.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= level;
    end

    assign change = level ^ prev_q;
endmodule

// File: rtl/defect_sticky.sv
// Module: sticky event bits with clear-on-read; a set in the clearing cycle wins.
// Assumes clr is a single-cycle strobe from the register decoder.
module defect_sticky #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] change,
    input  logic [W-1:0] enable,
    input  logic         clr,
    output logic [W-1:0] sticky
);
    logic [W-1:0] sticky_q;
    logic [W-1:0] keep;

    // Bits survive unless the status register is being read.
    always_comb keep = clr ? '0 : sticky_q;

    // Latch enabled changes; a new event overrides the clear.
    always_ff @(posedge clk) begin
        if (!rst_n) sticky_q <= '0;
        else        sticky_q <= keep | (change & enable);
    end

    assign sticky = sticky_q;
endmodule

// File: rtl/defect_irq_ctrl.sv
// Module: top of the defect change interrupt controller.
// Re-times three defect levels, detects changes, latches the enabled ones and
// drives an interrupt. Assumes single-cycle read and write strobes.
module defect_irq_ctrl
    import defect_irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              los_in,
    input  logic              sef_in,
    input  logic              lof_in,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_wdata,
    input  logic              reg_rd,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              irq
);
    localparam int PAD_W = REG_W - DEF_W;

    logic [DEF_W-1:0] raw_vec;
    logic [DEF_W-1:0] lvl_sync;
    logic [DEF_W-1:0] chg_evt;
    logic [DEF_W-1:0] en_q;
    logic [DEF_W-1:0] sticky_q;
    logic [REG_W-1:0] rd_mux;
    logic [REG_W-1:0] rdata_q;
    logic             rd_status;
    logic             unused_wdata;

    // Gather the defect pins into one vector in register bit order.
    always_comb begin
        raw_vec          = '0;
        raw_vec[BIT_LOS] = los_in;
        raw_vec[BIT_SEF] = sef_in;
        raw_vec[BIT_LOF] = lof_in;
    end

    defect_sync #(.W(DEF_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_async(raw_vec),
        .d_sync (lvl_sync)
    );

    defect_edge #(.W(DEF_W)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .level (lvl_sync),
        .change(chg_evt)
    );

    // Decode a read of the status register.
    always_comb rd_status = reg_rd && (reg_addr == A_STATUS);

    defect_sticky #(.W(DEF_W)) u_sticky (
        .clk   (clk),
        .rst_n (rst_n),
        .change(chg_evt),
        .enable(en_q),
        .clr   (rd_status),
        .sticky(sticky_q)
    );

    // Enable register: writable only at its own address.
    always_ff @(posedge clk) begin
        if (!rst_n)                             en_q <= '0;
        else if (reg_wr && reg_addr == A_ENABLE) en_q <= reg_wdata[DEF_W-1:0];
    end

    assign unused_wdata = ^reg_wdata[REG_W-1:DEF_W];

    // Select the addressed register, zero-padded to the bus width.
    always_comb begin
        case (reg_addr)
            A_ENABLE: rd_mux = {{PAD_W{1'b0}}, en_q};
            A_STATUS: rd_mux = {{PAD_W{1'b0}}, sticky_q};
            A_LEVEL:  rd_mux = {{PAD_W{1'b0}}, lvl_sync};
            default:  rd_mux = '0;
        endcase
    end

    // Capture read data on a read strobe and hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)      rdata_q <= '0;
        else if (reg_rd) rdata_q <= rd_mux;
    end

    assign reg_rdata = rdata_q;
    assign irq       = |sticky_q;
endmodule

// File: rtl/defect_irq_ctrl_chk.sv
// Module: assertion checker bound into defect_irq_ctrl.
// Assumes it sees the change, enable and sticky vectors of the top.
module defect_irq_ctrl_chk
    import defect_irq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              reg_rd,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [REG_W-1:0]  reg_rdata,
    input logic              irq,
    input logic [DEF_W-1:0]  chg,
    input logic [DEF_W-1:0]  en,
    input logic [DEF_W-1:0]  sticky
);
    logic rd_st;
    always_comb rd_st = reg_rd && (reg_addr == A_STATUS);

    genvar i;
    generate
        for (i = 0; i < DEF_W; i++) begin : g_bit
            // An enabled change always ends up latched, read or not.
            assert_latch_change_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (chg[i] && en[i]) |=> sticky[i]);
            // A clear bit stays clear without an enabled change.
            assert_disabled_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (!sticky[i] && !(chg[i] && en[i])) |=> !sticky[i]);
            // A status read clears a bit that has no new event.
            assert_clear_on_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (rd_st && !(chg[i] && en[i])) |=> !sticky[i]);
            // A set bit holds until a status read.
            assert_sticky_holds_R1: assert property (@(posedge clk) disable iff (!rst_n)
                (sticky[i] && !rd_st) |=> sticky[i]);
        end
    endgenerate

    // The interrupt rises only after an enabled change.
    assert_irq_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(chg & en) != '0));

    // Read data holds between read strobes.
    assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_rd && $past(rst_n)) |=> $stable(reg_rdata));

    // Leaving reset, the interrupt is low.
    assert_reset_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!irq && reg_rdata == '0));
endmodule

bind defect_irq_ctrl defect_irq_ctrl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_rd   (reg_rd),
    .reg_addr (reg_addr),
    .reg_rdata(reg_rdata),
    .irq      (irq),
    .chg      (chg_evt),
    .en       (en_q),
    .sticky   (sticky_q)
);

// File: tb/defect_irq_ctrl_tb.sv
`timescale 1ns/1ps
module defect_irq_ctrl_tb;
    logic       clk = 0;
    logic       rst_n = 0;
    logic [2:0] din = '0;
    logic [1:0] addr = '0;
    logic       wr = 0, rd = 0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq;
    int         checks = 0, fails = 0;
    bit         done = 0;

    always #2.5 clk = ~clk;

    defect_irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n),
        .los_in(din[0]), .sef_in(din[1]), .lof_in(din[2]),
        .reg_addr(addr), .reg_wr(wr), .reg_wdata(wdata),
        .reg_rd(rd), .reg_rdata(rdata), .irq(irq)
    );

    // Reference model: sample history queue plus behavioural registers.
    logic [2:0] hist[$];
    logic [2:0] m_en, m_st, m_old_st, m_old_en, m_chg, m_lvl;
    logic [7:0] m_rd;
    initial begin hist = '{3'b0, 3'b0, 3'b0}; m_en = 0; m_st = 0; m_rd = 0; end

    always @(posedge clk) begin
        if (!rst_n) begin
            hist = '{3'b0, 3'b0, 3'b0};
            m_en = 0; m_st = 0; m_rd = 0;
        end else begin
            m_chg    = hist[hist.size()-2] ^ hist[hist.size()-3];
            m_lvl    = hist[hist.size()-2];
            m_old_st = m_st;
            m_old_en = m_en;
            if (rd) begin
                case (addr)
                    2'd0: m_rd = {5'b0, m_old_en};
                    2'd1: m_rd = {5'b0, m_old_st};
                    2'd2: m_rd = {5'b0, m_lvl};
                    default: m_rd = 8'h00;
                endcase
            end
            if (rd && addr == 2'd1) m_st = 3'b0;
            m_st = m_st | (m_chg & m_old_en);
            if (wr && addr == 2'd0) m_en = wdata[2:0];
            hist.push_back(din);
            if (hist.size() > 6) void'(hist.pop_front());
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Compare against the model on every clock, away from the edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(irq == (|m_st), "R7 irq vs model", irq, |m_st);
            chk(rdata == m_rd, "R10 rdata vs model", rdata, m_rd);
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Called at a negedge; returns at a negedge with the read data captured.
    task automatic rd_reg(input logic [1:0] a, output logic [7:0] v);
        addr = a; rd = 1;
        @(negedge clk);
        rd = 0;
        v = rdata;
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr = 1;
        @(negedge clk);
        wr = 0;
    endtask

    initial begin
        logic [7:0] v;
        logic [7:0] hold;
        idle(3);
        chk(irq == 0, "R8 irq in reset", irq, 0);
        chk(rdata == 0, "R8 rdata in reset", rdata, 0);
        rst_n = 1;
        idle(1);
        rd_reg(2'd0, v); chk(v == 8'h00, "R8 enable after reset", v, 0);
        rd_reg(2'd1, v); chk(v == 8'h00, "R8 status after reset", v, 0);

        wr_reg(2'd0, 8'hFF);
        rd_reg(2'd0, v); chk(v == 8'h07, "R3 enable upper bits zero", v, 8'h07);

        // Rise of loss of signal: status set on third edge.
        din = 3'b001; idle(2);
        chk(irq == 0, "R1 no early latch", irq, 0);
        idle(1);
        chk(irq == 1, "R7 irq raised", irq, 1);
        rd_reg(2'd1, v); chk(v == 8'h01, "R1 los rise latched", v, 8'h01);
        chk(irq == 0, "R5 irq cleared by read", irq, 0);
        rd_reg(2'd1, v); chk(v == 8'h00, "R5 status cleared", v, 0);

        rd_reg(2'd2, v); chk(v == 8'h01, "R9 level reports los", v, 8'h01);
        wr_reg(2'd2, 8'h00); wr_reg(2'd1, 8'hFF);
        rd_reg(2'd2, v); chk(v == 8'h01, "R9 level write ignored", v, 8'h01);
        rd_reg(2'd1, v); chk(v == 8'h00, "R9 status write ignored", v, 0);

        din = 3'b000; idle(3);
        rd_reg(2'd1, v); chk(v == 8'h01, "R2 los fall latched", v, 8'h01);

        // Disabled change on severely errored frame.
        wr_reg(2'd0, 8'h05);
        din = 3'b010; idle(4);
        chk(irq == 0, "R4 disabled change no irq", irq, 0);
        wr_reg(2'd0, 8'h07); idle(2);
        rd_reg(2'd1, v); chk(v == 8'h00, "R4 not latched after enable", v, 0);
        din = 3'b000; idle(3);
        rd_reg(2'd1, v); chk(v == 8'h02, "R2 sef fall latched", v, 8'h02);

        din = 3'b100; idle(3);
        rd_reg(2'd1, v); chk(v == 8'h04, "R1 lof rise latched", v, 8'h04);

        // Read lands on the same edge as the latch.
        din = 3'b000; idle(2);
        rd_reg(2'd1, v); chk(v == 8'h00, "R6 read returns old status", v, 0);
        chk(irq == 1, "R6 irq kept", irq, 1);
        rd_reg(2'd1, v); chk(v == 8'h04, "R6 bit kept after read", v, 8'h04);

        din = 3'b011; idle(3);
        rd_reg(2'd1, v); chk(v == 8'h03, "R1 two defects together", v, 8'h03);

        hold = rdata; idle(3);
        chk(rdata == hold, "R10 rdata held", rdata, hold);

        // Random phase, judged by the per-clock model comparison.
        for (int k = 0; k < 400; k++) begin
            if ($urandom_range(0, 3) == 0) din = 3'($urandom);
            wr = ($urandom_range(0, 7) == 0);
            rd = ($urandom_range(0, 2) == 0);
            addr = 2'($urandom);
            wdata = 8'($urandom);
            @(negedge clk);
        end
        wr = 0; rd = 0;
        idle(2);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule